// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block produces the column address for every data beat of a double-data-rate SDRAM style burst. A mode-load strobe with an address word sets the burst length (2, 4 or 8 beats) and the beat ordering (wrapped sequential or XOR-interleaved). Each access command then supplies a starting column. On the following cycles the block emits one column per beat and marks the final beat.

The block is aligned to the burst length. The column bits above the block stay fixed for the whole burst. The low bits step through the block in the programmed order and wrap back inside the same block, so a burst never crosses into a neighbouring block. A command that arrives during a burst ends that burst, and the new sequence starts on the next cycle.

Mode words are checked before they are loaded. A word with a reserved length code, or with reserved operating-mode bits, raises an error pulse and changes nothing. A word that asks for a delay-line reset raises a separate pulse and still loads the burst settings. The delay line itself, CAS timing and data capture are handled by other logic.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `beat_valid`, `beat_last`, `mode_bad` and `dll_reset` are all 0. The reset mode is 8-beat sequential.
- R2: A mode word is accepted when `mode_word[12:7]` is zero. Its length code is `mode_word[2:0]`: 001 gives 2 beats, 010 gives 4 beats and 011 gives 8 beats. `mode_word[3]` selects the order, 0 for sequential and 1 for interleaved. The new mode applies to commands sampled on later clock edges.
- R3: On the cycle after `cmd_valid` is sampled, `beat_valid` is 1 and `beat_col` equals `cmd_col`.
- R4: Throughout a burst of length L = 2^n, `beat_col` bits above bit n-1 equal those of the starting column.
- R5: In sequential order, the low n bits of beat k are (start offset + k) mod L.
- R6: In interleaved order, the low n bits of beat k are (start offset XOR k).
- R7: `beat_last` is 1 on beat L-1 only. If no new command is sampled on that edge, `beat_valid` is 0 on the next cycle.
- R8: A command sampled during a burst abandons the remaining beats of that burst. The next cycle shows beat 0 of the new command, in the mode held at that time.
- R9: A mode word with a length code of 000 or 1xx pulses `mode_bad` for one cycle and leaves length and order unchanged.
- R10: A mode word with `mode_word[7]` set, or with any bit of `mode_word[12:9]` set, pulses `mode_bad` and is ignored. This rule has one exception, covered by R11.
- R11: A mode word whose bits [12:7] equal 000010 (only bit 8 set) pulses `dll_reset` for one cycle and loads length and order exactly as in R2.
- R12: A burst keeps the length and order captured with its command, even if a mode word is loaded while the burst runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Strobe: load `mode_word` |
| mode_word | input | 13 | Mode-register address word |
| cmd_valid | input | 1 | Access command strobe |
| cmd_col | input | 12 | Starting column of the access |
| beat_col | output | 12 | Column address of the current beat |
| beat_valid | output | 1 | `beat_col` holds a live beat |
| beat_last | output | 1 | Current beat is the final beat of the burst |
| mode_bad | output | 1 | One-cycle pulse: the last mode word was rejected |
| dll_reset | output | 1 | One-cycle pulse: the last mode word requested a delay-line reset |

## Verification
The assertions assume that the inputs are known and are sampled only on rising edges. They also assume that a mode error or reset pulse can only follow a `mode_load` on the cycle before. The bench drives every input at the falling edge and releases reset with `mode_load` and `cmd_valid` low. A scoreboard predicts each beat from a mode model that the bench keeps itself. The stimulus covers every length, both orders, starting offsets at and near the block end, commands that cut a burst off, and mode loads made in the middle of a burst.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // log2 of burst length: 1 -> 2 beats, 2 -> 4 beats, 3 -> 8 beats
    typedef struct packed {
        logic [1:0] lg;
        logic       ilv;
    } bmode_t;

    localparam int MAX_LG   = 3;
    localparam int BEAT_W   = MAX_LG;
    localparam int OP_LO    = 7;
    localparam int DLL_POS  = 1;   // bit 8 counted from OP_LO
    localparam bmode_t MODE_RST = '{lg: 2'd3, ilv: 1'b0};

    function automatic logic [BEAT_W-1:0] len_mask(input logic [1:0] lg);
        logic [BEAT_W:0] len;
        len = (BEAT_W+1)'(1) << lg;
        return BEAT_W'(len - (BEAT_W+1)'(1));
    endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
#(
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output bmode_t            mode,
    output logic              bad,
    output logic              dll
);
    localparam int OP_W = MODE_W - OP_LO;
    localparam logic [OP_W-1:0] DLL_PAT = OP_W'(1) << DLL_POS;

    typedef struct packed {
        bmode_t mode;
        logic   bad;
        logic   dll;
    } mstate_t;

    mstate_t st_d, st_q;

    logic [OP_W-1:0] op;
    logic            op_normal, op_dll, len_ok;
    logic [2:0]      unused_cl;

    assign op        = word[MODE_W-1:OP_LO];
    assign op_normal = (op == '0);
    assign op_dll    = (op == DLL_PAT);
    assign len_ok    = !word[2] && (word[1:0] != 2'b00);
    assign unused_cl = word[6:4];

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;
        st_d.dll = 1'b0;
        if (load) begin
            if ((op_normal || op_dll) && len_ok) begin
                st_d.mode.lg  = word[1:0];
                st_d.mode.ilv = word[3];
                st_d.dll      = op_dll;
            end else begin
                st_d.bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RST;
            st_q.bad  <= 1'b0;
            st_q.dll  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;
    assign bad  = st_q.bad;
    assign dll  = st_q.dll;
endmodule

// File: rtl/bcs_order.sv
module bcs_order
    import bcs_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic [COL_W-1:0]  start,
    input  bmode_t            mode,
    input  logic [BEAT_W-1:0] beat,
    output logic [COL_W-1:0]  col
);
    logic [BEAT_W-1:0] mask, off, low_seq, low_ilv, low;

    assign mask    = len_mask(mode.lg);
    assign off     = start[BEAT_W-1:0] & mask;
    assign low_seq = (off + beat) & mask;
    assign low_ilv = (off ^ beat) & mask;
    assign low     = mode.ilv ? low_ilv : low_seq;
    assign col     = {start[COL_W-1:BEAT_W], (start[BEAT_W-1:0] & ~mask) | low};
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W  = 12,
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              cmd_valid,
    input  logic [COL_W-1:0]  cmd_col,
    output logic [COL_W-1:0]  beat_col,
    output logic              beat_valid,
    output logic              beat_last,
    output logic              mode_bad,
    output logic              dll_reset
);
    typedef struct packed {
        logic              active;
        logic [BEAT_W-1:0] beat;
        bmode_t            mode;
        logic [COL_W-1:0]  start;
    } sstate_t;

    sstate_t s_d, s_q;
    bmode_t  cur_mode;
    logic    at_end;

    bcs_mode_reg #(.MODE_W(MODE_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .word  (mode_word),
        .mode  (cur_mode),
        .bad   (mode_bad),
        .dll   (dll_reset)
    );

    bcs_order #(.COL_W(COL_W)) u_order (
        .start (s_q.start),
        .mode  (s_q.mode),
        .beat  (s_q.beat),
        .col   (beat_col)
    );

    assign at_end = s_q.active && (s_q.beat == len_mask(s_q.mode.lg));

    always_comb begin
        s_d = s_q;
        if (cmd_valid) begin
            s_d.active = 1'b1;
            s_d.beat   = '0;
            s_d.mode   = cur_mode;
            s_d.start  = cmd_col;
        end else if (at_end) begin
            s_d.active = 1'b0;
        end else if (s_q.active) begin
            s_d.beat = s_q.beat + BEAT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.active <= 1'b0;
            s_q.beat   <= '0;
            s_q.mode   <= MODE_RST;
            s_q.start  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign beat_valid = s_q.active;
    assign beat_last  = at_end;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W  = 12,
    parameter int MODE_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_load,
    input logic [MODE_W-1:0] mode_word,
    input logic              cmd_valid,
    input logic [COL_W-1:0]  cmd_col,
    input logic [COL_W-1:0]  beat_col,
    input logic              beat_valid,
    input logic              beat_last,
    input logic              mode_bad,
    input logic              dll_reset
);
    logic [MODE_W-1:0] unused_word;
    assign unused_word = mode_word;

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (beat_valid && beat_col == $past(cmd_col)));  // R3

    AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !cmd_valid && !beat_last) |=>
            (beat_col[COL_W-1:3] == $past(beat_col[COL_W-1:3])));  // R4

    AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);  // R7

    AST_END_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !cmd_valid) |=> !beat_valid);  // R7

    AST_BAD_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bad |-> $past(mode_load));  // R9

    AST_DLL_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dll_reset |-> ($past(mode_load) && !mode_bad));  // R11

    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bad && !mode_load) |=> !mode_bad);  // R10
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (.*);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
    localparam int COL_W  = 12;
    localparam int MODE_W = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_load = 1'b0;
    logic [MODE_W-1:0] mode_word = '0;
    logic              cmd_valid = 1'b0;
    logic [COL_W-1:0]  cmd_col = '0;
    logic [COL_W-1:0]  beat_col;
    logic              beat_valid, beat_last, mode_bad, dll_reset;

    always #2 clk = ~clk;   // 250 MHz

    burst_col_seq #(.COL_W(COL_W), .MODE_W(MODE_W)) dut (.*);

    typedef struct {
        logic [COL_W-1:0] col;
        logic             last;
        string            req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    int   m_lg   = 3;
    bit   m_ilv  = 0;

    function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, int lg, bit ilv, int k);
        int len, off, lo;
        len = 1 << lg;
        off = int'(s) % len;
        lo  = ilv ? (off ^ k) : ((off + k) % len);
        return COL_W'((int'(s) / len) * len + lo);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // push n beats of a burst into the scoreboard, then issue the command
    task automatic burst(logic [COL_W-1:0] s, int n, string req);
        int len;
        len = 1 << m_lg;
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.col = exp_col(s, m_lg, m_ilv, k);
            e.last = (k == len - 1);
            e.req = req;
            exp_q.push_back(e);
        end
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_col   = s;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(string req);
        idle(10);
        check(exp_q.size() == 0, req, "beats missing", exp_q.size(), 0);
        check(!beat_valid, req, "valid after burst", beat_valid, 0);
        exp_q.delete();
    endtask

    task automatic mload(logic [MODE_W-1:0] w, bit ebad, bit edll, string req);
        @(negedge clk);
        mode_load = 1'b1;
        mode_word = w;
        @(negedge clk);
        mode_load = 1'b0;
        check(mode_bad == ebad, req, "mode_bad", mode_bad, ebad);
        check(dll_reset == edll, req, "dll_reset", dll_reset, edll);
        if (!ebad) begin
            m_lg  = int'(w[1:0]);
            m_ilv = w[3];
        end
        @(negedge clk);
        check(!mode_bad && !dll_reset, req, "pulse length", {mode_bad, dll_reset}, 0);
    endtask

    // monitor: pop and compare each live beat
    always @(negedge clk) begin
        if (rst_n && !done && beat_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected beat", beat_col, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(beat_col == e.col, e.req, "beat_col", beat_col, e.col);
                check(beat_last == e.last, e.req, "beat_last", beat_last, e.last);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        check(!beat_valid && !beat_last && !mode_bad && !dll_reset, "R1", "in reset",
              {beat_valid, beat_last, mode_bad, dll_reset}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!beat_valid && !beat_last && !mode_bad && !dll_reset, "R1", "after reset",
              {beat_valid, beat_last, mode_bad, dll_reset}, 0);
        // R1 default 8-beat sequential
        burst(12'h125, 8, "R1"); drain("R1");
        // R5 sequential lengths
        mload(13'h0003, 0, 0, "R2"); burst(12'h3FF, 8, "R5"); drain("R5");
        mload(13'h0002, 0, 0, "R2"); burst(12'h0A6, 4, "R5"); drain("R5");
        mload(13'h0001, 0, 0, "R2"); burst(12'hFFF, 2, "R4"); drain("R4");
        // R6 interleaved
        mload(13'h000B, 0, 0, "R2"); burst(12'h815, 8, "R6"); drain("R6");
        burst(12'h7F3, 8, "R6"); drain("R6");
        mload(13'h000A, 0, 0, "R2"); burst(12'h00E, 4, "R6"); drain("R6");
        mload(13'h0009, 0, 0, "R2"); burst(12'h201, 2, "R6"); drain("R6");
        // R7 back to back bursts: last beat followed by new command
        mload(13'h0002, 0, 0, "R2");
        burst(12'h013, 4, "R7"); idle(2); burst(12'h022, 4, "R7"); drain("R7");
        // R8 cut-off: second command two beats into an 8-beat burst
        mload(13'h0003, 0, 0, "R2");
        burst(12'h106, 2, "R8"); burst(12'h441, 8, "R8"); drain("R8");
        // R9 reserved length codes keep the 8-beat sequential mode
        mload(13'h0000, 1, 0, "R9"); mload(13'h000C, 1, 0, "R9");
        burst(12'h0F5, 8, "R9"); drain("R9");
        // R10 reserved operating bits
        mload(13'h0089, 1, 0, "R10"); mload(13'h0409, 1, 0, "R10"); mload(13'h0189, 1, 0, "R10");
        burst(12'h0F5, 8, "R10"); drain("R10");
        // R11 delay-line reset still loads settings
        mload(13'h010A, 0, 1, "R11"); burst(12'h0F5, 4, "R11"); drain("R11");
        // R12 mode change during a burst
        mload(13'h0003, 0, 0, "R2");
        burst(12'h356, 6, "R12");
        begin
            exp_t e;
            e.col = exp_col(12'h356, 3, 0, 6); e.last = 0; e.req = "R12"; exp_q.push_back(e);
            e.col = exp_col(12'h356, 3, 0, 7); e.last = 1; exp_q.push_back(e);
        end
        mload(13'h0009, 0, 0, "R12");
        drain("R12");
        burst(12'h356, 2, "R12"); drain("R12");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule